// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block produces eight edge-aligned pulse-width-modulated outputs from a single 16-bit up-counter. All channels share one period, and each channel sets only its own compare threshold. The counter advances on one of three tick-enable inputs, selected by an encoded field. The chosen tick passes through a power-of-two prescaler. The counter runs from a programmable start value up to a modulo value, then reloads.

A simple word-addressed write port configures the timer. Each output can be inverted, or masked to a forced level. An optional per-channel enable can silence an output completely. A lock bit protects the timing configuration against stray writes until software explicitly unlocks it. New modulo and compare values are double-buffered and only take effect at a period boundary, so a running waveform never sees a truncated period.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset the counter reads 0 and is stopped, all eight outputs are 0, every channel is masked with a forced level of 0, and the lock is off.
- R2: The clock field, bits [1:0] of the setup register at offset 0x00, selects the counting tick: 0 stops the counter, 1 selects `sysTick`, 2 selects `fixTick`, and 3 selects `extTick`. Ticks from an unselected input have no effect on the counter.
- R3: The prescaler field, bits [4:2] of the setup register, holds a value p from 0 to 7. The counter advances once for every 2^p selected ticks.
- R4: The counter counts up by one per prescaled tick. In the step after it equals the active modulo value (offset 0x08), it loads the start value (offset 0x0C) instead.
- R5: The control register of channel n (offset 0x60+4n, bit 0) enables PWM mode. In PWM mode the channel is active while the counter is below the channel's active compare value (offset 0x40+4n), and inactive from the match to the end of the period. With bit 0 clear, the channel is inactive. `pwmOut` is registered and reflects the counter one clock later.
- R6: A compare value of 0 gives a channel that is always inactive. A compare value greater than the modulo value gives a channel that is always active. Both cases are measured before inversion.
- R7: Bit n of the invert register (offset 0x18) inverts the level of channel n.
- R8: When bit n of the mask register (offset 0x1C) is set, output n takes bit n of the forced-level register (offset 0x20), whatever the counter and compare values are.
- R9: Writing 1 to bit 0 of the lock register (offset 0x10) turns the lock on. While it is on, writes to the clock and prescaler fields, the modulo register, the compare registers, the channel control registers and the invert register are discarded. Writes to the mask, forced-level, start-value and channel-enable fields still take effect.
- R10: Writing 1 to bit 0 of the unlock register (offset 0x14) turns the lock off. Writing 0 to the lock bit does not clear it.
- R11: A written modulo or compare value moves to the active copy only at a counter reload, or on the next clock while the clock field is 0.
- R12: Bit 16+n of the setup register enables channel n. While that bit is clear, output n is 0, overriding mask, forced level and inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysTick | input | 1 | System-rate tick enable (clock code 1) |
| fixTick | input | 1 | Fixed-rate tick enable (clock code 2) |
| extTick | input | 1 | External tick enable (clock code 3) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte address of the write; bits [1:0] ignored |
| wrData | input | 32 | Write data |
| pwmOut | output | 8 | Channel outputs, bit n for channel n |
| cntValue | output | 16 | Current counter value |

## Verification
A register write can arrive in the same cycle as a counter reload. In that cycle the active copies must take the old buffered value, and the new value must wait for the next boundary. The bench provokes this with short modulo values and random writes landing on every cycle phase. A cycle-level reference model in the bench judges each cycle on both `cntValue` and `pwmOut`. A lock or unlock write can also meet a protected write back to back. The random mix of lock, unlock and protected writes checks that the write cycle itself sees the lock state from before that write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PS_W   = 3;
  localparam int SRC_N  = 3;
  localparam int EN_LSB = 16;

  // word-aligned register offsets
  localparam logic [ADDR_W-1:0] A_SETUP    = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODULO   = 8'h08;
  localparam logic [ADDR_W-1:0] A_START    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_LOCK     = 8'h10;
  localparam logic [ADDR_W-1:0] A_UNLOCK   = 8'h14;
  localparam logic [ADDR_W-1:0] A_INVERT   = 8'h18;
  localparam logic [ADDR_W-1:0] A_MASK     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_FORCE    = 8'h20;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 8'h40;
  localparam logic [ADDR_W-1:0] A_CTL_BASE = 8'h60;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             run;
    logic [SRC_N-1:0] srcHot;
    logic [PS_W-1:0]  psSel;
  } timerCtl_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CNT_W       = 16,
  parameter int HAS_CHAN_EN = 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  output timerCtl_t                      tmrCtl,
  output logic [CNT_W-1:0]               modShadow,
  output logic [CNT_W-1:0]               startVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmpShadow,
  output logic [NUM_CH-1:0]              chanPwm,
  output logic [NUM_CH-1:0]              invMask,
  output logic [NUM_CH-1:0]              outMask,
  output logic [NUM_CH-1:0]              forceVal,
  output logic [NUM_CH-1:0]              chanOn,
  output logic                           wpOn
);

  function automatic logic hitReg(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] r);
    return a[ADDR_W-1:2] == r[ADDR_W-1:2];
  endfunction

  srcSel_e         srcSel;
  logic [PS_W-1:0] psSel;
  logic            cfgOk;
  logic            unusedBits;

  assign cfgOk      = wrEn && !wpOn;
  assign unusedBits = ^{wrData, wrAddr[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel    <= SRC_OFF;
      psSel     <= '0;
      modShadow <= '0;
      startVal  <= '0;
      invMask   <= '0;
      outMask   <= '1;
      forceVal  <= '0;
      wpOn      <= 1'b0;
    end else begin
      if (cfgOk && hitReg(wrAddr, A_SETUP)) begin
        srcSel <= srcSel_e'(wrData[1:0]);
        psSel  <= wrData[2 +: PS_W];
      end
      if (cfgOk && hitReg(wrAddr, A_MODULO)) modShadow <= wrData[CNT_W-1:0];
      if (cfgOk && hitReg(wrAddr, A_INVERT)) invMask   <= wrData[NUM_CH-1:0];
      if (wrEn && hitReg(wrAddr, A_START))   startVal  <= wrData[CNT_W-1:0];
      if (wrEn && hitReg(wrAddr, A_MASK))    outMask   <= wrData[NUM_CH-1:0];
      if (wrEn && hitReg(wrAddr, A_FORCE))   forceVal  <= wrData[NUM_CH-1:0];
      if (wrEn && hitReg(wrAddr, A_UNLOCK) && wrData[0])    wpOn <= 1'b0;
      else if (wrEn && hitReg(wrAddr, A_LOCK) && wrData[0]) wpOn <= 1'b1;
    end
  end

  always_comb begin
    tmrCtl.run    = srcSel != SRC_OFF;
    tmrCtl.psSel  = psSel;
    tmrCtl.srcHot = '0;
    case (srcSel)
      SRC_SYS: tmrCtl.srcHot[0] = 1'b1;
      SRC_FIX: tmrCtl.srcHot[1] = 1'b1;
      SRC_EXT: tmrCtl.srcHot[2] = 1'b1;
      default: tmrCtl.srcHot = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    localparam logic [ADDR_W-1:0] CMP_A = A_CMP_BASE + ADDR_W'(4 * g);
    localparam logic [ADDR_W-1:0] CTL_A = A_CTL_BASE + ADDR_W'(4 * g);
    logic [CNT_W-1:0] cmpQ;
    logic             modeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ  <= '0;
        modeQ <= 1'b0;
      end else begin
        if (cfgOk && hitReg(wrAddr, CMP_A)) cmpQ  <= wrData[CNT_W-1:0];
        if (cfgOk && hitReg(wrAddr, CTL_A)) modeQ <= wrData[0];
      end
    end
    assign cmpShadow[g] = cmpQ;
    assign chanPwm[g]   = modeQ;
  end

  if (HAS_CHAN_EN != 0) begin : gEn
    logic [NUM_CH-1:0] enQ;
    always_ff @(posedge clk) begin
      if (!rstN) enQ <= '0;
      else if (wrEn && hitReg(wrAddr, A_SETUP)) enQ <= wrData[EN_LSB +: NUM_CH];
    end
    assign chanOn = enQ;
  end else begin : gNoEn
    assign chanOn = '1;
  end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  timerCtl_t                    tmrCtl,
  input  logic                         sysTick,
  input  logic                         fixTick,
  input  logic                         extTick,
  input  logic [CNT_W-1:0]             modShadow,
  input  logic [CNT_W-1:0]             startVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmpShadow,
  input  logic [NUM_CH-1:0]            chanPwm,
  input  logic [NUM_CH-1:0]            invMask,
  input  logic [NUM_CH-1:0]            outMask,
  input  logic [NUM_CH-1:0]            forceVal,
  input  logic [NUM_CH-1:0]            chanOn,
  output logic [CNT_W-1:0]             cntValue,
  output logic [NUM_CH-1:0]            pwmOut
);

  localparam int PSC_W = (1 << PS_W) - 1;

  logic [PSC_W-1:0]  psCnt;
  logic [PSC_W-1:0]  psLimit;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  modAct;
  logic              tickHit;
  logic              adv;
  logic              reload;
  logic              takeShadow;
  logic [NUM_CH-1:0] pinNext;

  assign psLimit    = (PSC_W'(1) << tmrCtl.psSel) - PSC_W'(1);
  assign tickHit    = |(tmrCtl.srcHot & {extTick, fixTick, sysTick});
  assign adv        = tmrCtl.run && tickHit && (psCnt == psLimit);
  assign reload     = adv && (cnt == modAct);
  assign takeShadow = !tmrCtl.run || reload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt  <= '0;
      cnt    <= '0;
      modAct <= '0;
    end else begin
      if (!tmrCtl.run)  psCnt <= '0;
      else if (tickHit) psCnt <= (psCnt == psLimit) ? '0 : psCnt + PSC_W'(1);
      if (adv)          cnt   <= reload ? startVal : cnt + CNT_W'(1);
      if (takeShadow)   modAct <= modShadow;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gOut
    logic [CNT_W-1:0] cmpAct;
    always_ff @(posedge clk) begin
      if (!rstN)           cmpAct <= '0;
      else if (takeShadow) cmpAct <= cmpShadow[g];
    end
    assign pinNext[g] = !chanOn[g] ? 1'b0 :
                        outMask[g] ? forceVal[g] :
                        ((chanPwm[g] && (cnt < cmpAct)) ^ invMask[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwmOut <= '0;
    else       pwmOut <= pinNext;
  end

  assign cntValue = cnt;

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CNT_W       = 16,
  parameter int HAS_CHAN_EN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysTick,
  input  logic              fixTick,
  input  logic              extTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [CNT_W-1:0]  cntValue
);

  timerCtl_t                    tmrCtl;
  logic [CNT_W-1:0]             modShadow;
  logic [CNT_W-1:0]             startVal;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpShadow;
  logic [NUM_CH-1:0]            chanPwm;
  logic [NUM_CH-1:0]            invMask;
  logic [NUM_CH-1:0]            outMask;
  logic [NUM_CH-1:0]            forceVal;
  logic [NUM_CH-1:0]            chanOn;
  logic                         wpOn;
  logic                         timerRun;

  assign timerRun = tmrCtl.run;

  pwm_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .HAS_CHAN_EN(HAS_CHAN_EN)) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tmrCtl(tmrCtl), .modShadow(modShadow), .startVal(startVal), .cmpShadow(cmpShadow),
    .chanPwm(chanPwm), .invMask(invMask), .outMask(outMask), .forceVal(forceVal),
    .chanOn(chanOn), .wpOn(wpOn)
  );

  pwm_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) coreInst (
    .clk(clk), .rstN(rstN), .tmrCtl(tmrCtl),
    .sysTick(sysTick), .fixTick(fixTick), .extTick(extTick),
    .modShadow(modShadow), .startVal(startVal), .cmpShadow(cmpShadow),
    .chanPwm(chanPwm), .invMask(invMask), .outMask(outMask), .forceVal(forceVal),
    .chanOn(chanOn), .cntValue(cntValue), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_shared_timer_chk.sv
module pwm_shared_timer_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [CNT_W-1:0]  cntValue,
  input logic [NUM_CH-1:0] pwmOut,
  input logic              timerRun,
  input logic [CNT_W-1:0]  startVal,
  input logic [CNT_W-1:0]  modShadow,
  input logic [NUM_CH-1:0] outMask,
  input logic [NUM_CH-1:0] forceVal,
  input logic [NUM_CH-1:0] chanOn,
  input logic              wpOn
);

  logic unusedLow;
  assign unusedLow = ^wrAddr[1:0];

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerRun |=> $stable(cntValue));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntValue) |-> (cntValue == CNT_W'($past(cntValue) + 1'b1)) || (cntValue == $past(startVal)));

  // R8
  mask_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmOut ^ $past(forceVal)) & $past(chanOn & outMask)) == '0);

  // R12
  chan_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~$past(chanOn)) == '0);

  // R9
  lock_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wpOn && wrEn && (wrAddr[ADDR_W-1:2] == A_MODULO[ADDR_W-1:2])) |=> $stable(modShadow));

  // R10
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr[ADDR_W-1:2] == A_UNLOCK[ADDR_W-1:2]) && wrData[0]) |=> !wpOn);

endmodule

bind pwm_shared_timer pwm_shared_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cntValue(cntValue), .pwmOut(pwmOut), .timerRun(timerRun), .startVal(startVal),
  .modShadow(modShadow), .outMask(outMask), .forceVal(forceVal), .chanOn(chanOn),
  .wpOn(wpOn)
);

// File: tb/tb_pwm_shared_timer.sv
module tb_pwm_shared_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysTick = 1'b0, fixTick = 1'b0, extTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  pwmOut;
  logic [15:0] cntValue;

  int    nChk = 0, nErr = 0;
  bit    finished = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  pwm_shared_timer dut (
    .clk(clk), .rstN(rstN), .sysTick(sysTick), .fixTick(fixTick), .extTick(extTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut), .cntValue(cntValue)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [1:0]  mClk;
  logic [2:0]  mPs;
  logic [6:0]  mPsCnt, mLim;
  logic [15:0] mCnt, mModS, mModA, mStart;
  logic [15:0] mCmpS [8];
  logic [15:0] mCmpA [8];
  logic [7:0]  mMode, mInv, mMask, mForce, mEn, mOut, nOut;
  logic        mWp, mRun, mHit, mAdv, mRaw;
  logic [2:0]  tickV;

  function automatic void mApply(input logic [7:0] a, input logic [31:0] d);
    logic ok;
    ok = !mWp;
    if (a[7:2] == 6'h00) begin
      if (ok) begin mClk = d[1:0]; mPs = d[4:2]; end
      mEn = d[23:16];
    end
    if (a[7:2] == 6'h02 && ok) mModS = d[15:0];
    if (a[7:2] == 6'h03) mStart = d[15:0];
    if (a[7:2] == 6'h06 && ok) mInv = d[7:0];
    if (a[7:2] == 6'h07) mMask = d[7:0];
    if (a[7:2] == 6'h08) mForce = d[7:0];
    if (a[7:2] == 6'h05 && d[0]) mWp = 1'b0;
    else if (a[7:2] == 6'h04 && d[0]) mWp = 1'b1;
    if (a[7:5] == 3'b010 && ok) mCmpS[a[4:2]] = d[15:0];
    if (a[7:5] == 3'b011 && ok) mMode[a[4:2]] = d[0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mClk = 0; mPs = 0; mPsCnt = 0; mCnt = 0; mModS = 0; mModA = 0; mStart = 0;
      mMode = 0; mInv = 0; mMask = 8'hFF; mForce = 0; mEn = 0; mOut = 0; mWp = 0;
      for (int i = 0; i < 8; i++) begin mCmpS[i] = 0; mCmpA[i] = 0; end
    end else begin
      tickV = {extTick, fixTick, sysTick};
      mRun  = mClk != 2'd0;
      mHit  = mRun ? tickV[mClk - 2'd1] : 1'b0;
      mLim  = (7'd1 << mPs) - 7'd1;
      mAdv  = mHit && (mPsCnt == mLim);
      for (int i = 0; i < 8; i++) begin
        mRaw = mMode[i] && (mCnt < mCmpA[i]);
        nOut[i] = !mEn[i] ? 1'b0 : mMask[i] ? mForce[i] : (mRaw ^ mInv[i]);
      end
      if (!mRun) begin
        mPsCnt = 0; mModA = mModS;
        for (int i = 0; i < 8; i++) mCmpA[i] = mCmpS[i];
      end else begin
        if (mHit) mPsCnt = (mPsCnt == mLim) ? 7'd0 : mPsCnt + 7'd1;
        if (mAdv) begin
          if (mCnt == mModA) begin
            mCnt = mStart; mModA = mModS;
            for (int i = 0; i < 8; i++) mCmpA[i] = mCmpS[i];
          end else mCnt = mCnt + 16'd1;
        end
      end
      mOut = nOut;
      if (wrEn) mApply(wrAddr, wrData);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk);
    chk({curTag, " counter"}, 32'(cntValue), 32'(mCnt));
    chk({curTag, " outputs"}, 32'(pwmOut), 32'(mOut));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick1();
    wrEn = 1'b0;
  endtask

  task automatic waitCnt(input logic [15:0] v, input int lim);
    for (int i = 0; i < lim && cntValue != v; i++) tick1();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [15:0] rec;
    logic        seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 counter", 32'(cntValue), 0);
    chk("R1 outputs", 32'(pwmOut), 0);
    rstN = 1'b1;
    run(3);
    chk("R1 stopped", 32'(cntValue), 0);

    // R5 basic edge-aligned operation, modulo 9, compare 2n
    curTag = "R5";
    wr(8'h08, 32'd9);
    for (int i = 0; i < 8; i++) begin
      wr(8'h40 + 8'(4 * i), 32'(2 * i));
      wr(8'h60 + 8'(4 * i), 32'd1);
    end
    wr(8'h1C, 32'h00);
    sysTick = 1'b1;
    wr(8'h00, 32'h00FF_0001);
    run(30);
    // R6 compare 0 never active, compare 14 > modulo 9 always active
    curTag = "R6";
    for (int i = 0; i < 12; i++) begin
      tick1();
      chk("R6 ch0 low", 32'(pwmOut[0]), 0);
      chk("R6 ch7 high", 32'(pwmOut[7]), 1);
    end

    // R7 inversion
    curTag = "R7";
    wr(8'h18, 32'hF0);
    run(2);
    chk("R7 ch7 inverted", 32'(pwmOut[7]), 0);
    chk("R7 ch0 not inverted", 32'(pwmOut[0]), 0);
    run(12);

    // R8 mask with forced level, R12 channel enable override
    curTag = "R8";
    wr(8'h20, 32'hFF);
    wr(8'h1C, 32'hFF);
    run(2);
    chk("R8 forced ones", 32'(pwmOut), 32'hFF);
    wr(8'h1C, 32'h0F);
    wr(8'h20, 32'h05);
    run(2);
    chk("R8 forced low nibble", 32'(pwmOut[3:0]), 32'h5);
    curTag = "R12";
    wr(8'h1C, 32'hFF);
    wr(8'h20, 32'hFF);
    wr(8'h00, 32'h003F_0001);
    run(2);
    chk("R12 disabled channels low", 32'(pwmOut), 32'h3F);
    wr(8'h00, 32'h00FF_0001);
    wr(8'h1C, 32'h00);
    wr(8'h18, 32'h00);
    run(4);

    // R4 reload to start value
    curTag = "R4";
    wr(8'h0C, 32'd3);
    waitCnt(16'd9, 40);
    chk("R4 reached modulo", 32'(cntValue), 9);
    tick1();
    chk("R4 reload to start", 32'(cntValue), 3);
    wr(8'h0C, 32'd0);
    waitCnt(16'd9, 40);
    tick1();
    chk("R4 reload to zero", 32'(cntValue), 0);
    run(3);

    // R2 clock source selection
    curTag = "R2";
    wr(8'h00, 32'h00FF_0002);
    rec = cntValue;
    run(10);
    chk("R2 unselected tick ignored", 32'(cntValue), 32'(rec));
    fixTick = 1'b1; sysTick = 1'b0;
    run(1);
    rec = cntValue;
    tick1();
    chk("R2 fixed tick counts", 32'(cntValue != rec), 1);
    wr(8'h00, 32'h00FF_0003);
    fixTick = 1'b0; extTick = 1'b1;
    rec = cntValue;
    tick1();
    chk("R2 external tick counts", 32'(cntValue != rec), 1);
    wr(8'h00, 32'h00FF_0000);
    rec = cntValue;
    run(8);
    chk("R2 clock off holds", 32'(cntValue), 32'(rec));
    extTick = 1'b0;

    // R11 stopped timer takes the new modulo at once; R3 prescaler /4
    curTag = "R3";
    wr(8'h08, 32'd1000);
    sysTick = 1'b1;
    wr(8'h00, 32'h00FF_0009);
    run(3);
    rec = cntValue;
    run(8);
    chk("R3 two steps in eight ticks", 32'(cntValue), 32'(rec + 16'd2));
    run(5);

    // R11 buffered modulo while running
    curTag = "R11";
    wr(8'h00, 32'h00FF_0001);
    wr(8'h08, 32'd5);
    run(20);
    chk("R11 old modulo still active", 32'(cntValue > 16'd5), 1);
    waitCnt(16'd5, 1200);
    chk("R11 new modulo reached", 32'(cntValue), 5);
    tick1();
    chk("R11 reload after new modulo", 32'(cntValue), 0);

    // R9 lock discards protected writes, keeps unprotected ones
    curTag = "R9";
    wr(8'h10, 32'd1);
    wr(8'h08, 32'd2);
    wr(8'h00, 32'h00FF_0000);
    wr(8'h1C, 32'hFF);
    wr(8'h20, 32'h00);
    run(8);
    chk("R9 mask write landed", 32'(pwmOut), 0);
    seen = 1'b0;
    for (int i = 0; i < 14; i++) begin
      tick1();
      if (cntValue == 16'd5) seen = 1'b1;
    end
    chk("R9 modulo and clock writes ignored", 32'(seen), 1);
    wr(8'h10, 32'd0);

    // R10 unlock makes writes effective again
    curTag = "R10";
    wr(8'h14, 32'd1);
    wr(8'h08, 32'd2);
    run(10);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick1();
      if (cntValue > 16'd2) seen = 1'b1;
    end
    chk("R10 new modulo after unlock", 32'(seen), 0);

    // constrained random mix, judged by the model every cycle
    curTag = "RND";
    for (int i = 0; i < 6000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int          pick;
      {extTick, fixTick, sysTick} = 3'($urandom);
      if (($urandom % 5) == 0) begin
        pick = int'($urandom % 25);
        if (pick < 9) a = 8'(4 * pick);
        else if (pick < 17) a = 8'h40 + 8'(4 * (pick - 9));
        else a = 8'h60 + 8'(4 * (pick - 17));
        d = $urandom;
        if (a == 8'h00) d = d & 32'h00FF_001F;
        else if (a == 8'h08 || a == 8'h0C || a[7:5] == 3'b010) d = d & 32'h3F;
        else d = d & 32'hFF;
        wr(a, d);
      end else tick1();
    end
    report();
  end
endmodule